// File: doc/BRIEF.md
# Asynchronous Frame to SPI Master Bridge

This block listens to a serial bus that carries bytes framed by one low start bit and one high stop bit, each bit lasting a fixed number of clocks. It oversamples the line, confirms each start bit at mid-bit, samples the data bits in the middle of their cells, checks the stop bit, and then hands the byte to a host over an SPI link on which the block is the master. The host sees an SPI slave transfer with clock polarity 0 and data launched on the leading edge (CPOL=0, CPHA=1). One SCK pulse is produced per bus bit time. The host's own outgoing byte is shifted in on the same pulses.

An active-low select output marks the time a byte is in flight, from a confirmed start bit until the host transfer is over, so it can drive the host's slave-select pin. A stop bit sampled low raises a framing flag. While the flag is up, frames are still received but the host is not clocked. The flag drops once the bus has stayed high long enough to mark the end of a message. A one-cycle strobe with the received byte, and one with the host's byte, are also brought out.

Top module: `async_spi_bridge`

## Requirements
- R1: While reset is asserted, sckOut=0, ctrlN=1, frameErr=0, rxValid=0 and hostValid=0.
- R2: A falling edge of the synchronized bus starts a candidate frame. If the bus is high again at the half-bit point (BIT_CLKS/2 clocks later), the candidate is dropped. Nothing is received, no SCK pulse is made and ctrlN stays high.
- R3: Data bits go least significant first, one per BIT_CLKS clocks, and are sampled at mid-cell. If busIn falls between rising edges n and n+1, then at edge n+SYNC_STAGES+1+BIT_CLKS/2+9*BIT_CLKS (n+155 with the bench's BIT_CLKS=16) the stop bit is sampled. If it is high, rxValid is high for that one cycle with rxByte.
- R4: The edge that accepts a good stop bit also starts the host transfer, provided frameErr is low. It gives 8 SCK pulses with period BIT_CLKS, each high BIT_CLKS/2 clocks, and SCK idles low. The first rising edge appears at that same edge.
- R5: mosiOut carries the received byte most significant bit first. It changes only at SCK rising edges and holds while SCK is high.
- R6: misoIn is captured at each SCK falling edge, most significant bit first. hostValid pulses with hostByte BIT_CLKS*8 clocks after the transfer starts, while SCK is low.
- R7: ctrlN is low from the confirmed start bit through the end of the host transfer, high when the block is idle, and always low while SCK is high.
- R8: A stop bit sampled low sets frameErr at that sampling edge, gives no rxValid and starts no transfer.
- R9: While frameErr is set, later frames still give rxValid, but no SCK pulse is produced.
- R10: frameErr stays set until the bus has been high for EOM_BITS*BIT_CLKS consecutive clocks, and then clears.
- R11: A frame whose start bit follows the previous stop bit by one clock is received and transferred correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the oversampling clock |
| rstN | input | 1 | Active-low synchronous reset |
| busIn | input | 1 | Bus sense input, high when idle |
| sckOut | output | 1 | SPI clock to the host, idles low |
| mosiOut | output | 1 | Serial data to the host |
| misoIn | input | 1 | Serial data from the host |
| ctrlN | output | 1 | Active-low byte-in-flight select |
| frameErr | output | 1 | Framing error flag, held until end of message |
| rxValid | output | 1 | One-cycle strobe, byte received |
| rxByte | output | DATA_BITS | Byte received from the bus |
| hostValid | output | 1 | One-cycle strobe, host transfer finished |
| hostByte | output | DATA_BITS | Byte shifted in from the host |

## Verification
The receive strobe is due a fixed SYNC_STAGES+1+BIT_CLKS/2+9*BIT_CLKS edges after the edge before the start bit falls. The bench records that edge for every frame it sends and compares it with the cycle in which rxValid is seen. The first SCK rise is due in that same cycle, and hostValid exactly 8*BIT_CLKS cycles later. The framing flag must rise in the stop-sampling cycle of the bad frame. All outputs are sampled on the falling clock edge, so each registered change is seen in the first half-cycle after the edge that makes it. The clearing of the framing flag is bracketed instead: the flag is checked set 9 bit times into an idle stretch and clear after 12.

// File: rtl/asb_pkg.sv
package asb_pkg;

  typedef enum logic [1:0] {
    RX_HUNT,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_e;

  // strobes issued by the control towards the datapath
  typedef struct packed {
    logic rxSample;     // shift one bus data bit in
    logic rxDone;       // good stop bit: publish received byte
    logic txLoad;       // start host transfer with received byte
    logic txShift;      // next bit onto mosi (SCK rising)
    logic hostCapture;  // capture miso (SCK falling)
    logic hostDone;     // host transfer complete
  } asb_strobe_t;

endpackage

// File: rtl/asb_ctrl.sv
module asb_ctrl
  import asb_pkg::*;
#(
  parameter int BIT_CLKS    = 128,
  parameter int DATA_BITS   = 8,
  parameter int EOM_BITS    = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busIn,
  output logic        busS,
  output logic        sckOut,
  output logic        ctrlN,
  output logic        frameErr,
  output asb_strobe_t stb
);

  localparam int CNT_W    = $clog2(BIT_CLKS);
  localparam int IDX_W    = $clog2(DATA_BITS);
  localparam int EOM_CLKS = EOM_BITS * BIT_CLKS;
  localparam int IDLE_W   = $clog2(EOM_CLKS + 1);
  localparam logic [CNT_W-1:0]  HALF_M1  = CNT_W'(BIT_CLKS / 2 - 1);
  localparam logic [CNT_W-1:0]  BIT_M1   = CNT_W'(BIT_CLKS - 1);
  localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(DATA_BITS - 1);
  localparam logic [IDLE_W-1:0] EOM_MAX  = IDLE_W'(EOM_CLKS);
  localparam logic [IDLE_W-1:0] EOM_M1   = IDLE_W'(EOM_CLKS - 1);

  // input synchronizer
  logic [SYNC_STAGES-1:0] syncQ;
  generate
    if (SYNC_STAGES == 1) begin : g_sync_one
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= busIn;
      end
    end else begin : g_sync_chain
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], busIn};
      end
    end
  endgenerate
  assign busS = syncQ[SYNC_STAGES-1];

  logic busPrev;
  always_ff @(posedge clk) begin
    if (!rstN) busPrev <= 1'b1;
    else       busPrev <= busS;
  end

  // receive sequencer
  rx_state_e       rxState;
  logic [CNT_W-1:0] rxCnt;
  logic [IDX_W-1:0] rxIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxState <= RX_HUNT;
      rxCnt   <= '0;
      rxIdx   <= '0;
    end else begin
      case (rxState)
        RX_HUNT: begin
          if (!busS && busPrev) begin
            rxState <= RX_START;
            rxCnt   <= '0;
          end
        end
        RX_START: begin
          if (rxCnt == HALF_M1) begin
            rxCnt <= '0;
            if (!busS) begin
              rxState <= RX_DATA;
              rxIdx   <= '0;
            end else begin
              rxState <= RX_HUNT;
            end
          end else begin
            rxCnt <= rxCnt + 1'b1;
          end
        end
        RX_DATA: begin
          if (rxCnt == BIT_M1) begin
            rxCnt <= '0;
            if (rxIdx == LAST_IDX) rxState <= RX_STOP;
            else                   rxIdx   <= rxIdx + 1'b1;
          end else begin
            rxCnt <= rxCnt + 1'b1;
          end
        end
        default: begin
          if (rxCnt == BIT_M1) begin
            rxCnt   <= '0;
            rxState <= RX_HUNT;
          end else begin
            rxCnt <= rxCnt + 1'b1;
          end
        end
      endcase
    end
  end

  logic stopTick, stopOk, stopBad;
  assign stopTick = (rxState == RX_STOP) && (rxCnt == BIT_M1);
  assign stopOk   = stopTick && busS;
  assign stopBad  = stopTick && !busS;

  // host shift engine
  logic             shiftBusy;
  logic [CNT_W-1:0] txCnt;
  logic [IDX_W-1:0] txIdx;
  logic             bitEnd;
  assign bitEnd = shiftBusy && (txCnt == BIT_M1);

  always_comb begin
    stb.rxSample    = (rxState == RX_DATA) && (rxCnt == BIT_M1);
    stb.rxDone      = stopOk;
    stb.txLoad      = stopOk && !frameErr;
    stb.hostCapture = shiftBusy && (txCnt == HALF_M1);
    stb.txShift     = bitEnd && (txIdx != LAST_IDX);
    stb.hostDone    = bitEnd && (txIdx == LAST_IDX);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftBusy <= 1'b0;
      txCnt     <= '0;
      txIdx     <= '0;
      sckOut    <= 1'b0;
    end else if (stb.txLoad) begin
      shiftBusy <= 1'b1;
      txCnt     <= '0;
      txIdx     <= '0;
      sckOut    <= 1'b1;
    end else if (shiftBusy) begin
      if (txCnt == HALF_M1) sckOut <= 1'b0;
      if (txCnt == BIT_M1) begin
        txCnt <= '0;
        if (txIdx == LAST_IDX) begin
          shiftBusy <= 1'b0;
        end else begin
          txIdx  <= txIdx + 1'b1;
          sckOut <= 1'b1;
        end
      end else begin
        txCnt <= txCnt + 1'b1;
      end
    end
  end

  // end-of-message detection and framing flag
  logic [IDLE_W-1:0] idleCnt;
  logic eomTick;
  assign eomTick = busS && (idleCnt == EOM_M1);

  always_ff @(posedge clk) begin
    if (!rstN)                  idleCnt <= '0;
    else if (!busS)             idleCnt <= '0;
    else if (idleCnt != EOM_MAX) idleCnt <= idleCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)        frameErr <= 1'b0;
    else if (stopBad) frameErr <= 1'b1;
    else if (eomTick) frameErr <= 1'b0;
  end

  assign ctrlN = !((rxState == RX_DATA) || (rxState == RX_STOP) || shiftBusy);

  AST_SCK_SELECTED: assert property (@(posedge clk) disable iff (!rstN)
    sckOut |-> !ctrlN); // R7
  AST_LOAD_WHEN_FREE: assert property (@(posedge clk) disable iff (!rstN)
    stb.txLoad |-> !shiftBusy); // R11
  AST_REJECT_KEEPS_SELECT: assert property (@(posedge clk) disable iff (!rstN)
    (rxState == RX_START) && (rxCnt == HALF_M1) && busS |=> ctrlN || shiftBusy); // R2

endmodule

// File: rtl/asb_dp.sv
module asb_dp
  import asb_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busS,
  input  logic                 misoIn,
  input  asb_strobe_t          stb,
  output logic                 mosiOut,
  output logic                 rxValid,
  output logic [DATA_BITS-1:0] rxByte,
  output logic                 hostValid,
  output logic [DATA_BITS-1:0] hostByte
);

  logic [DATA_BITS-1:0] rxSh;
  logic [DATA_BITS-1:0] txSh;
  logic [DATA_BITS-1:0] hostSh;

  // bus side: least significant bit arrives first
  always_ff @(posedge clk) begin
    if (!rstN)             rxSh <= '0;
    else if (stb.rxSample) rxSh <= {busS, rxSh[DATA_BITS-1:1]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxValid <= 1'b0;
      rxByte  <= '0;
    end else begin
      rxValid <= stb.rxDone;
      if (stb.rxDone) rxByte <= rxSh;
    end
  end

  // host side: most significant bit first
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txSh    <= '0;
      mosiOut <= 1'b0;
    end else if (stb.txLoad) begin
      mosiOut <= rxSh[DATA_BITS-1];
      txSh    <= rxSh << 1;
    end else if (stb.txShift) begin
      mosiOut <= txSh[DATA_BITS-1];
      txSh    <= txSh << 1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                hostSh <= '0;
    else if (stb.hostCapture) hostSh <= {hostSh[DATA_BITS-2:0], misoIn};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hostValid <= 1'b0;
      hostByte  <= '0;
    end else begin
      hostValid <= stb.hostDone;
      if (stb.hostDone) hostByte <= hostSh;
    end
  end

  AST_RX_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid); // R3
  AST_HOST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    hostValid |=> !hostValid); // R6

endmodule

// File: rtl/async_spi_bridge.sv
module async_spi_bridge
  import asb_pkg::*;
#(
  parameter int BIT_CLKS    = 128,
  parameter int DATA_BITS   = 8,
  parameter int EOM_BITS    = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busIn,
  output logic                 sckOut,
  output logic                 mosiOut,
  input  logic                 misoIn,
  output logic                 ctrlN,
  output logic                 frameErr,
  output logic                 rxValid,
  output logic [DATA_BITS-1:0] rxByte,
  output logic                 hostValid,
  output logic [DATA_BITS-1:0] hostByte
);

  logic        busS;
  asb_strobe_t stb;

  asb_ctrl #(
    .BIT_CLKS   (BIT_CLKS),
    .DATA_BITS  (DATA_BITS),
    .EOM_BITS   (EOM_BITS),
    .SYNC_STAGES(SYNC_STAGES)
  ) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .busIn   (busIn),
    .busS    (busS),
    .sckOut  (sckOut),
    .ctrlN   (ctrlN),
    .frameErr(frameErr),
    .stb     (stb)
  );

  asb_dp #(
    .DATA_BITS(DATA_BITS)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .busS     (busS),
    .misoIn   (misoIn),
    .stb      (stb),
    .mosiOut  (mosiOut),
    .rxValid  (rxValid),
    .rxByte   (rxByte),
    .hostValid(hostValid),
    .hostByte (hostByte)
  );

  AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    sckOut && $past(sckOut) |-> $stable(mosiOut)); // R5
  AST_NO_VALID_ON_ERR: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frameErr) |-> !rxValid); // R8
  AST_QUIET_IN_ERROR: assert property (@(posedge clk) disable iff (!rstN)
    frameErr |-> !$rose(sckOut)); // R9
  AST_HOST_DONE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    hostValid |-> !sckOut); // R6

endmodule

// File: tb/async_spi_bridge_tb_top.sv
module async_spi_bridge_tb_top;

  localparam int BIT  = 16;
  localparam int HALF = BIT / 2;
  localparam int LAT  = 3 + HALF + 9 * BIT;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busIn = 1'b1;
  logic misoIn = 1'b0;
  logic sckOut, mosiOut, ctrlN, frameErr, rxValid, hostValid;
  logic [7:0] rxByte, hostByte;

  always #10 clk = ~clk;

  async_spi_bridge #(
    .BIT_CLKS   (BIT),
    .DATA_BITS  (8),
    .EOM_BITS   (10),
    .SYNC_STAGES(2)
  ) dut_i (
    .clk      (clk),
    .rstN     (rstN),
    .busIn    (busIn),
    .sckOut   (sckOut),
    .mosiOut  (mosiOut),
    .misoIn   (misoIn),
    .ctrlN    (ctrlN),
    .frameErr (frameErr),
    .rxValid  (rxValid),
    .rxByte   (rxByte),
    .hostValid(hostValid),
    .hostByte (hostByte)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int errs = 0;
  int checks = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] hostPattern(input int x);
    return 8'((x * 29 + 7) & 255);
  endfunction

  // expectations written by the driver
  int expS[512];
  int expB[512];
  int nRx = 0;
  int xS[512];
  int xB[512];
  int nX = 0;
  int expErrS = -1;

  // monitor state
  int rxIdx = 0;
  int xIdx = 0;
  int pCnt = 0;
  int highLen = 0;
  logic [7:0] mosiCol = '0;
  logic [7:0] hostTx = '0;
  logic sckPrev = 1'b0;
  logic errPrev = 1'b0;

  always @(negedge clk) begin
    if (rstN) begin
      if (rxValid) begin
        if (rxIdx < nRx) begin
          check(cyc == expS[rxIdx], "R3 rxValid cycle", cyc, expS[rxIdx]);
          check(int'(rxByte) == expB[rxIdx], "R3 rxByte", rxByte, expB[rxIdx]);
        end else begin
          check(1'b0, "R2/R8 unexpected rxValid", rxByte, -1);
        end
        rxIdx++;
      end
      if (sckOut && !sckPrev) begin
        check(!ctrlN, "R7 ctrlN low at SCK rise", ctrlN, 0);
        if (pCnt == 0) begin
          if (xIdx < nX) check(cyc == xS[xIdx], "R4 transfer start cycle", cyc, xS[xIdx]);
          else           check(1'b0, "R9 SCK without expected transfer", cyc, -1);
          hostTx = hostPattern(xIdx);
        end
        misoIn = hostTx[7];
        hostTx = hostTx << 1;
        pCnt++;
        highLen = 0;
      end
      if (sckOut) highLen++;
      if (!sckOut && sckPrev) begin
        check(highLen == HALF, "R4 SCK high length", highLen, HALF);
        mosiCol = {mosiCol[6:0], mosiOut};
      end
      if (hostValid) begin
        check(pCnt == 8, "R4 SCK pulse count", pCnt, 8);
        if (xIdx < nX) begin
          check(int'(mosiCol) == xB[xIdx], "R5 MOSI byte", mosiCol, xB[xIdx]);
          check(cyc == xS[xIdx] + 8 * BIT, "R6 hostValid cycle", cyc, xS[xIdx] + 8 * BIT);
        end
        check(hostByte == hostPattern(xIdx), "R6 hostByte", hostByte, hostPattern(xIdx));
        xIdx++;
        pCnt = 0;
      end
      if (frameErr && !errPrev) check(cyc == expErrS, "R8 frameErr rise cycle", cyc, expErrS);
      sckPrev = sckOut;
      errPrev = frameErr;
    end
  end

  task automatic sendFrame(input logic [7:0] b, input logic stopBit, input bit xfer);
    @(negedge clk);
    busIn = 1'b0;
    if (stopBit) begin
      expS[nRx] = cyc + LAT;
      expB[nRx] = int'(b);
      nRx++;
      if (xfer) begin
        xS[nX] = cyc + LAT;
        xB[nX] = int'(b);
        nX++;
      end
    end else begin
      expErrS = cyc + LAT;
    end
    repeat (BIT) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      busIn = b[i];
      repeat (BIT) @(negedge clk);
    end
    busIn = stopBit;
    repeat (BIT) @(negedge clk);
    busIn = 1'b1;
  endtask

  task automatic idleBits(input int k);
    repeat (k * BIT) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    check(sckOut == 1'b0, "R1 sckOut in reset", sckOut, 0);
    check(ctrlN == 1'b1, "R1 ctrlN in reset", ctrlN, 1);
    check(frameErr == 1'b0, "R1 frameErr in reset", frameErr, 0);
    check(rxValid == 1'b0, "R1 rxValid in reset", rxValid, 0);
    check(hostValid == 1'b0, "R1 hostValid in reset", hostValid, 0);
    rstN = 1'b1;
    idleBits(2);

    // R2: short low pulses are rejected at mid start bit
    for (int len = 1; len <= HALF - 2; len++) begin
      int lowSeen = 0;
      @(negedge clk);
      busIn = 1'b0;
      repeat (len) @(negedge clk);
      busIn = 1'b1;
      repeat (2 * BIT) begin
        @(negedge clk);
        if (!ctrlN || sckOut) lowSeen++;
      end
      check(lowSeen == 0, "R2 glitch activity", lowSeen, 0);
    end

    // R3..R7, R11: every byte value, frames back to back
    for (int v = 0; v < 256; v++) sendFrame(8'(v), 1'b1, 1'b1);
    idleBits(12);
    check(rxIdx == nRx, "R11 all sweep bytes received", rxIdx, nRx);
    check(xIdx == nX, "R11 all sweep transfers done", xIdx, nX);

    // R8: bad stop bit
    sendFrame(8'hA5, 1'b0, 1'b0);
    idleBits(2);
    check(frameErr == 1'b1, "R8 frameErr after bad stop", frameErr, 1);
    // R9: frame during error is received but not clocked out
    sendFrame(8'h3C, 1'b1, 1'b0);
    idleBits(9);
    check(frameErr == 1'b1, "R10 frameErr held before end of message", frameErr, 1);
    idleBits(3);
    check(frameErr == 1'b0, "R10 frameErr cleared by end of message", frameErr, 0);
    check(rxIdx == nRx, "R9 frame received during error", rxIdx, nRx);

    // transfers resume after end of message
    sendFrame(8'h00, 1'b1, 1'b1);
    sendFrame(8'hFF, 1'b1, 1'b1);
    sendFrame(8'h81, 1'b1, 1'b1);
    idleBits(12);
    check(rxIdx == nRx, "R3 final received count", rxIdx, nRx);
    check(xIdx == nX, "R4 final transfer count", xIdx, nX);
    check(ctrlN == 1'b1, "R7 ctrlN high when idle", ctrlN, 1);
    check(sckOut == 1'b0, "R4 SCK idles low", sckOut, 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule